// File: doc/BRIEF.md
# Nibble-Masked Single-Port RAM with Power-Save Gating

This block is a synchronous single-port memory whose write path is masked one 4-bit nibble at a time. The full-size configuration holds 16384 words of 16 bits, for 256 kbit in total. A single select input, a write/read direction and a 4-bit nibble mask drive every access. The result of a read appears on `rdata` after the clock edge that performed it. The read word is captured once at that edge, and the array itself adds no further output register.

Three power-control inputs put the memory into one of three reduced states. In standby the output holds its value. In sleep the output reads zero and the contents are kept. In power-off the contents are discarded. When more than one input is raised, the strongest state wins. If a user ties all three inputs to 0, the block behaves as a plain RAM.

A parameter adds an extra output register in the fabric. This costs one more cycle of read latency. The address width is also a parameter: the full-size part uses `ADDR_W` = 14, and the default is smaller so that the elaborated array stays small. Words that have never been written, or that were lost in power-off, read back as the parameter value `FILL`.

Top module: `sp_nibram`

## Requirements
- R1: A write takes place on a rising edge where `sel`=1, `wr_en`=1 and no power input is high. Only the nibbles whose `nib_mask` bit is 1 change. A mask of 0, or `sel`=0, changes nothing.
- R2: A read takes place on a rising edge where `sel`=1, `wr_en`=0 and no power input is high. With `PIPE`=0, `rdata` shows the addressed word right after that edge and holds it until the next read. An edge with `sel`=0 leaves `rdata` unchanged.
- R3: Mask bit k guards data bits [4k+3:4k]. Bit 0 covers bits 3..0 and bit 3 covers bits 15..12.
- R4: While `pwr_standby` is the only power input high, accesses are ignored. Once standby has spanned two edges, `rdata` does not change.
- R5: While `pwr_sleep` is high and `pwr_off` is low, `rdata` is 0 and accesses are ignored. Stored words survive sleep.
- R6: While `pwr_off` is high, `rdata` is 0 and accesses are ignored. After power-off, every word reads as `FILL` until it is written again.
- R7: Priority runs power-off, then sleep, then standby. Standby together with sleep gives 0 on `rdata`. Sleep together with power-off loses the contents.
- R8: With `PIPE`=1, the output register loads only on the edge that follows a read. The read word therefore appears one cycle later than with `PIPE`=0, and is gated in the same way.
- R9: In normal state, a write or idle edge does not change `rdata` unless a read was pending in the pipeline.
- R10: After reset, `rdata` is 0 and every word reads as `FILL`.
- R11: A partial-mask write to a word holding no valid data fills the unmasked nibbles from `FILL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Access select |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| nib_mask | input | DATA_W/4 | Per-nibble write enable |
| pwr_standby | input | 1 | Standby request |
| pwr_sleep | input | 1 | Sleep request |
| pwr_off | input | 1 | Power-off request |
| rdata | output | DATA_W | Read data |

## Verification
The bench uses a non-zero `FILL` value and runs the same stimulus through a direct instance and a pipelined instance. This exposes:
- a design that loses the pipeline bubble, because its output moves one cycle early;
- a design that writes unmasked nibbles, or that reorders nibble lanes, because the readback is wrong;
- a design that lets standby or sleep pass a write, or that returns stale data after power-off, because the word read afterwards is wrong;
- a design that inverts the power priority, because with standby and sleep both high it would hold the old data instead of driving 0;
- a design that keeps stale nibbles on a fresh word after a partial write, because those nibbles would not read as `FILL`.

// File: rtl/sp_nibram_pkg.sv
package sp_nibram_pkg;
  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_STBY  = 2'd1,
    PS_SLEEP = 2'd2,
    PS_OFF   = 2'd3
  } pstate_e;
endpackage

// File: rtl/sp_nibram_pwr.sv
module sp_nibram_pwr
  import sp_nibram_pkg::*;
(
  input  logic    standby,
  input  logic    sleep,
  input  logic    off,
  output pstate_e state
);
  // power-off dominates sleep, sleep dominates standby
  always_comb begin
    if (off)          state = PS_OFF;
    else if (sleep)   state = PS_SLEEP;
    else if (standby) state = PS_STBY;
    else              state = PS_RUN;
  end
endmodule

// File: rtl/sp_nibram_array.sv
module sp_nibram_array
  import sp_nibram_pkg::*;
#(
  parameter int              ADDR_W = 10,
  parameter int              DATA_W = 16,
  parameter int              NIB_W  = 4,
  parameter logic [DATA_W-1:0] FILL = '0,
  localparam int             DEPTH  = 1 << ADDR_W,
  localparam int             MASK_W = DATA_W / NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pstate_e           state,
  input  logic              sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [MASK_W-1:0] mask,
  output logic [DATA_W-1:0] rd_word,
  output logic              rd_fire
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  valid;
  logic              do_wr, do_rd, word_ok;
  logic [MASK_W-1:0] nib_we;
  logic [DATA_W-1:0] nib_data;

  assign do_wr   = sel && wr_en  && (state == PS_RUN);
  assign do_rd   = sel && !wr_en && (state == PS_RUN);
  assign word_ok = valid[addr];

  // a word without valid data takes FILL in its unmasked nibbles
  for (genvar g = 0; g < MASK_W; g++) begin : g_nib
    assign nib_we[g] = mask[g] || !word_ok;
    assign nib_data[g*NIB_W +: NIB_W] = mask[g] ? wdata[g*NIB_W +: NIB_W]
                                                : FILL[g*NIB_W +: NIB_W];
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      for (int g = 0; g < MASK_W; g++) begin
        if (nib_we[g]) mem[addr][g*NIB_W +: NIB_W] <= nib_data[g*NIB_W +: NIB_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= '0;
      rd_word <= '0;
      rd_fire <= 1'b0;
    end else if (state == PS_OFF) begin
      valid   <= '0;
      rd_word <= FILL;
      rd_fire <= 1'b0;
    end else begin
      rd_fire <= do_rd;
      if (do_wr) valid[addr] <= 1'b1;
      if (do_rd) rd_word <= word_ok ? mem[addr] : FILL;
    end
  end
endmodule

// File: rtl/sp_nibram_out.sv
module sp_nibram_out
  import sp_nibram_pkg::*;
#(
  parameter int                PIPE   = 0,
  parameter int                DATA_W = 16,
  parameter logic [DATA_W-1:0] FILL   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pstate_e           state,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              rd_fire,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] held;

  if (PIPE != 0) begin : g_pipe
    logic [DATA_W-1:0] pq;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pq <= '0;
      else if (state == PS_OFF)  pq <= FILL;
      else if (rd_fire)          pq <= rd_word;
    end
    assign held = pq;
  end else begin : g_direct
    logic unused_fire;
    assign unused_fire = rd_fire;
    assign held = rd_word;
  end

  assign rdata = (state == PS_SLEEP || state == PS_OFF) ? '0 : held;
endmodule

// File: rtl/sp_nibram.sv
module sp_nibram
  import sp_nibram_pkg::*;
#(
  parameter int                ADDR_W = 10,
  parameter int                DATA_W = 16,
  parameter int                PIPE   = 0,
  parameter logic [DATA_W-1:0] FILL   = '0,
  localparam int               NIB_W  = 4,
  localparam int               MASK_W = DATA_W / NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [MASK_W-1:0] nib_mask,
  input  logic              pwr_standby,
  input  logic              pwr_sleep,
  input  logic              pwr_off,
  output logic [DATA_W-1:0] rdata
);
  pstate_e           state;
  logic [DATA_W-1:0] rd_word;
  logic              rd_fire;

  sp_nibram_pwr u_pwr (
    .standby (pwr_standby),
    .sleep   (pwr_sleep),
    .off     (pwr_off),
    .state   (state)
  );

  sp_nibram_array #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .NIB_W (NIB_W), .FILL (FILL)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state),
    .sel     (sel),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .mask    (nib_mask),
    .rd_word (rd_word),
    .rd_fire (rd_fire)
  );

  sp_nibram_out #(
    .PIPE (PIPE), .DATA_W (DATA_W), .FILL (FILL)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state),
    .rd_word (rd_word),
    .rd_fire (rd_fire),
    .rdata   (rdata)
  );
endmodule

// File: rtl/sp_nibram_chk.sv
module sp_nibram_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              wr_en,
  input logic              pwr_standby,
  input logic              pwr_sleep,
  input logic              pwr_off,
  input logic [DATA_W-1:0] rdata
);
  logic [1:0] age;
  logic       run, stby_only, rd_now;

  assign run       = !pwr_standby && !pwr_sleep && !pwr_off;
  assign stby_only = pwr_standby && !pwr_sleep && !pwr_off;
  assign rd_now    = run && sel && !wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R5: sleep forces zero output
  p_sleep_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_sleep && !pwr_off) |-> (rdata == '0));

  // R6: power-off forces zero output
  p_off_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off |-> (rdata == '0));

  // R4: output frozen once standby spans two edges
  p_stby_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && stby_only && $past(stby_only) && $past(stby_only, 2))
      |-> $stable(rdata));

  // R9: no read in flight -> output stays put in normal state
  p_nord_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && run && $past(run) && !$past(rd_now) && !$past(rd_now, 2))
      |-> $stable(rdata));

  // R7: standby together with sleep behaves as sleep
  p_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_standby && pwr_sleep) |-> (rdata == '0));
endmodule

bind sp_nibram sp_nibram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel         (sel),
  .wr_en       (wr_en),
  .pwr_standby (pwr_standby),
  .pwr_sleep   (pwr_sleep),
  .pwr_off     (pwr_off),
  .rdata       (rdata)
);

// File: tb/test_sp_nibram.sv
module test_sp_nibram;
  localparam int          AW    = 10;
  localparam int          DEPTH = 1 << AW;
  localparam logic [15:0] FILLV = 16'hA5C3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 0, wr_en = 0, st = 0, sl = 0, of = 0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic [3:0]    mask = '0;
  logic [15:0]   rdata0, rdata1;

  always #5 clk = ~clk;

  sp_nibram #(.ADDR_W(AW), .DATA_W(16), .PIPE(0), .FILL(FILLV)) i_sp_nibram (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .nib_mask(mask), .pwr_standby(st), .pwr_sleep(sl),
    .pwr_off(of), .rdata(rdata0));

  sp_nibram #(.ADDR_W(AW), .DATA_W(16), .PIPE(1), .FILL(FILLV)) i_sp_nibram_pipe (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .nib_mask(mask), .pwr_standby(st), .pwr_sleep(sl),
    .pwr_off(of), .rdata(rdata1));

  typedef struct { logic [15:0] e0; logic [15:0] e1; string tag; } item_t;
  item_t sbq[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  bit [15:0] mm [DEPTH];
  bit        mv [DEPTH];
  bit [15:0] rl, pq;
  bit        pend;

  task automatic step(input bit c, input bit w, input logic [AW-1:0] a,
                      input logic [15:0] d, input logic [3:0] m,
                      input bit s0, input bit s1, input bit s2, input string tag);
    item_t it;
    bit [15:0] pq_n;
    bit        pend_n;
    bit        runs;
    @(negedge clk);
    sel = c; wr_en = w; addr = a; wdata = d; mask = m; st = s0; sl = s1; of = s2;
    @(posedge clk);
    runs   = !s0 && !s1 && !s2;
    pq_n   = pend ? rl : pq;
    pend_n = 0;
    if (s2) begin
      for (int i = 0; i < DEPTH; i++) mv[i] = 0;
      rl = FILLV; pq_n = FILLV;
    end else if (runs && c) begin
      if (w) begin
        for (int g = 0; g < 4; g++)
          if (m[g] || !mv[a]) mm[a][g*4 +: 4] = m[g] ? d[g*4 +: 4] : FILLV[g*4 +: 4];
        mv[a] = 1;
      end else begin
        rl = mv[a] ? mm[a] : FILLV;
        pend_n = 1;
      end
    end
    pq = pq_n; pend = pend_n;
    it.e0 = (s1 || s2) ? 16'h0 : rl;
    it.e1 = (s1 || s2) ? 16'h0 : pq;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input logic [3:0] m,
                    input string tag);
    step(1, 1, a, d, m, 0, 0, 0, tag);
  endtask
  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(1, 0, a, 16'h0, 4'h0, 0, 0, 0, tag);
  endtask
  task automatic idle(input string tag);
    step(0, 0, '0, 16'h0, 4'h0, 0, 0, 0, tag);
  endtask

  // monitor: samples 2 ns after each edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        checks += 2;
        if (rdata0 !== it.e0) begin
          fails++;
          $display("FAIL %s direct: actual %h expected %h", it.tag, rdata0, it.e0);
        end
        if (rdata1 !== it.e1) begin
          fails++;
          $display("FAIL %s pipelined: actual %h expected %h", it.tag, rdata1, it.e1);
        end
      end
    end
  end

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mm[i] = 0; mv[i] = 0; end
    rl = 0; pq = 0; pend = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    idle("R10 reset output");
    rd(10'd5, "R10 unwritten reads FILL");
    idle("R8 pipe bubble");
    wr(10'd5, 16'h1234, 4'hF, "R1 full write");
    rd(10'd5, "R2 read back");
    idle("R8 pipe delayed");
    wr(10'd5, 16'hABCD, 4'b0101, "R3 nibble lanes 0 and 2");
    idle("R9 write leaves output");
    rd(10'd5, "R3 expect 1B3D");
    wr(10'd5, 16'hFFFF, 4'h0, "R1 zero mask");
    rd(10'd5, "R1 zero mask no change");
    step(0, 0, 10'd5, 16'h0, 4'h0, 0, 0, 0, "R2 select low");
    step(0, 1, 10'd5, 16'h9999, 4'hF, 0, 0, 0, "R1 select low write");
    rd(10'd5, "R1 select low kept");
    wr(10'd9, 16'h7000, 4'b1000, "R11 partial on fresh");
    rd(10'd9, "R11 expect 75C3");
    wr(10'd9, 16'h0F00, 4'b0100, "R11 second partial");
    rd(10'd9, "R11 expect 7FC3");
    idle("R8 settle");
    step(1, 0, 10'd9, 16'h0, 4'h0, 1, 0, 0, "R4 standby read ignored");
    step(1, 1, 10'd5, 16'h0000, 4'hF, 1, 0, 0, "R4 standby write ignored");
    step(0, 0, 10'd5, 16'h0, 4'h0, 1, 0, 0, "R4 standby hold");
    rd(10'd5, "R4 contents after standby");
    step(1, 1, 10'd5, 16'h0000, 4'hF, 0, 1, 0, "R5 sleep write ignored");
    step(1, 0, 10'd9, 16'h0, 4'h0, 0, 1, 0, "R5 sleep output zero");
    step(0, 0, 10'd9, 16'h0, 4'h0, 1, 1, 0, "R7 standby plus sleep");
    rd(10'd5, "R5 contents survive sleep");
    idle("R8 settle");
    step(0, 0, 10'd0, 16'h0, 4'h0, 0, 1, 1, "R7 off plus sleep");
    step(1, 1, 10'd5, 16'h4444, 4'hF, 0, 0, 1, "R6 off write ignored");
    rd(10'd5, "R6 contents lost");
    rd(10'd9, "R6 contents lost other word");
    wr(10'd9, 16'h00E0, 4'b0010, "R11 partial after off");
    rd(10'd9, "R11 expect A5E3");
    for (int i = 0; i < 16; i++)
      wr(AW'(i * 67 + 3), 16'(i * 16'h1111 ^ 16'h0F0F), 4'hF, "R1 sweep write");
    wr(10'd1023, 16'hBEEF, 4'hF, "R1 top address");
    for (int i = 0; i < 16; i++)
      rd(AW'(i * 67 + 3), "R2 back-to-back reads");
    rd(10'd1023, "R2 top address");
    idle("R8 last pipe");
    idle("R9 idle");
    repeat (4) @(posedge clk);
    finish_up();
  end
endmodule